// File: doc/BRIEF.md
# UTOPIA Level-2 Slave Transmit Port

This block is the sending half of a slave device on a shared UTOPIA Level-2 multi-PHY bus. Local logic writes one ATM cell into a single-cell buffer, one bus word at a time. Once the cell is complete, the port reports that it has a cell. It does so only in the cycle after the bus master presents this port's 5-bit PHY address.

When the master asserts the enable while the port is addressed, the port starts the cell. Each enabled clock edge launches the next word, which appears on the bus in the following cycle. A start-of-cell flag marks the first word, and an odd parity bit covers each word. A gap in the enable pauses the cell. After the last word, the buffer is free again for the local side.

The data width is 8 bits (53 words per cell) or 16 bits (27 words per cell, including one pad byte), chosen by `DATA_W`. Every output is registered on the rising clock edge. The bus drivers are represented by output-enable flags instead of tri-state pins.

Top module: `utopia_tx_slave`

## Requirements
- R1: A cell is 53 words when `DATA_W` is 8 and 27 words when it is 16. Words leave on the bus in the order the local side wrote them, and exactly that many words lie between two consecutive start-of-cell words.
- R2: `wr_ready` is high exactly while the buffer does not hold a complete cell. A write (`wr_en` high) while `wr_ready` is low is ignored and does not alter the held cell.
- R3: `tx_clav_oe` is high in the cycle after a rising edge at which `tx_addr` equals `cfg_phy_id`, and low otherwise. `tx_clav` is never high while `tx_clav_oe` is low.
- R4: `tx_clav` is high in the cycle after an edge with a matching address only if, after that edge, the buffer holds a complete cell whose sending has not begun.
- R5: At an edge where `tx_enb` is high and either a cell is in progress, or the address matches and a complete cell is held, a word is launched. In the next cycle `tx_data_oe` is high and `tx_data` carries that word. In every other cycle `tx_data_oe`, `tx_data`, `tx_soc` and `tx_prty` are all 0.
- R6: `tx_soc` is high exactly in the cycles that carry word 0 of a cell.
- R7: While `tx_data_oe` is high, the XOR of `tx_data` and `tx_prty` is 1 (odd parity).
- R8: If `tx_enb` is low at an edge in the middle of a cell, no word is launched and the position within the cell is kept. Once a cell has started, later words do not depend on `tx_addr`.
- R9: The edge that launches the last word frees the buffer. From then on `wr_ready` is 1 and `tx_clav` is 0 until a new complete cell has been written.
- R10: With no cell in progress, `tx_enb` high together with a non-matching address launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all signals are sampled and launched on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_phy_id | input | 5 | PHY address this port answers to |
| wr_en | input | 1 | Local write strobe for one cell word |
| wr_data | input | DATA_W | Local cell word |
| wr_ready | output | 1 | Buffer can accept words |
| tx_addr | input | 5 | PHY address driven by the bus master |
| tx_enb | input | 1 | Master enable, active high: launch a word for the next cycle |
| tx_data | output | DATA_W | Transmit data word, msb is bit DATA_W-1 |
| tx_data_oe | output | 1 | Drive enable for data, start-of-cell and parity |
| tx_soc | output | 1 | High with the first word of a cell |
| tx_prty | output | 1 | Odd parity over tx_data |
| tx_clav | output | 1 | Cell available in answer to a poll |
| tx_clav_oe | output | 1 | Drive enable for tx_clav |

## Verification
Two things can fall on one edge: a poll answer and a change in buffer state. One case is a poll at the edge that stores the final word of a cell; the other is a poll together with a write attempt at the edge that launches the last word. Directed sequences provoke both. A long constrained-random run with mixed addresses, enable gaps and write strobes provokes them many times more. A bench model built from the requirements predicts, for every cycle, the availability answer, the ready flag, and whether and which word is launched. The outputs are compared with that model one cycle after each edge.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

  // Words per cell for a given bus width (16-bit mode carries one pad byte)
  function automatic int unsigned cell_words(input int unsigned dw);
    return (dw == 16) ? 27 : 53;
  endfunction

  // Odd parity bit: the XOR of the word and this bit is 1
  function automatic logic odd_parity(input logic [15:0] w);
    return ~(^w);
  endfunction

endpackage

// File: rtl/utx_cell_buffer.sv
module utx_cell_buffer #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WORDS  = 53,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              release_i,
  output logic [DATA_W-1:0] rd_word,
  output logic              full_o,
  output logic              wr_ready_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic [DATA_W-1:0] mem [WORDS];
  logic [IDX_W-1:0]  wr_idx_q;
  logic              full_q;
  logic              accept;

  assign accept     = wr_en && !full_q;
  assign wr_ready_o = !full_q;
  assign full_o     = full_q;
  assign rd_word    = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_idx_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      full_q   <= 1'b0;
    end else if (release_i) begin
      full_q   <= 1'b0;
      wr_idx_q <= '0;
    end else if (accept) begin
      if (wr_idx_q == LAST_IDX) begin
        full_q   <= 1'b1;
        wr_idx_q <= '0;
      end else begin
        wr_idx_q <= wr_idx_q + 1'b1;
      end
    end
  end

  AST_FULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !release_i |=> full_q); // R2
  AST_RELEASE_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> full_q); // R9
  AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx_q <= LAST_IDX); // R1

endmodule

// File: rtl/utx_launch.sv
module utx_launch #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WORDS  = 53,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enb,
  input  logic              addr_hit,
  input  logic              cell_full,
  input  logic [DATA_W-1:0] rd_word,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              release_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_data_oe,
  output logic              tx_soc,
  output logic              tx_prty
);
  import utx_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  tx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              launch;
  logic              last_word;
  logic [DATA_W-1:0] data_q;
  logic              oe_q, soc_q, prty_q;

  assign launch    = tx_enb && ((state_q == ST_SEND) || (addr_hit && cell_full));
  assign last_word = launch && (idx_q == LAST_IDX);
  assign release_o = last_word;
  assign busy_o    = (state_q == ST_SEND) || launch;
  assign rd_idx    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (launch) begin
      if (last_word) begin
        state_q <= ST_IDLE;
        idx_q   <= '0;
      end else begin
        state_q <= ST_SEND;
        idx_q   <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      oe_q   <= 1'b0;
      soc_q  <= 1'b0;
      prty_q <= 1'b0;
    end else if (launch) begin
      data_q <= rd_word;
      oe_q   <= 1'b1;
      soc_q  <= (state_q == ST_IDLE);
      prty_q <= odd_parity(16'(rd_word));
    end else begin
      data_q <= '0;
      oe_q   <= 1'b0;
      soc_q  <= 1'b0;
      prty_q <= 1'b0;
    end
  end

  assign tx_data    = data_q;
  assign tx_data_oe = oe_q;
  assign tx_soc     = soc_q;
  assign tx_prty    = prty_q;

  AST_PARITY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (^{data_q, prty_q}) == 1'b1); // R7
  AST_SOC_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    soc_q |-> oe_q); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> (data_q == '0) && !prty_q); // R5
  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND) && !tx_enb |=> $stable(idx_q) && !oe_q); // R8
  AST_NO_STRAY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) && !addr_hit |=> !oe_q); // R10

endmodule

// File: rtl/utx_clav.sv
module utx_clav (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_hit,
  input  logic cell_full,
  input  logic busy,
  output logic tx_clav,
  output logic tx_clav_oe
);
  logic clav_q, clav_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clav_q    <= 1'b0;
      clav_oe_q <= 1'b0;
    end else begin
      clav_oe_q <= addr_hit;
      clav_q    <= addr_hit && cell_full && !busy;
    end
  end

  assign tx_clav    = clav_q;
  assign tx_clav_oe = clav_oe_q;

  AST_CLAV_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    clav_q |-> clav_oe_q); // R3
  AST_CLAV_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_full |=> !clav_q); // R4

endmodule

// File: rtl/utopia_tx_slave.sv
module utopia_tx_slave #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_phy_id,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic              tx_enb,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_data_oe,
  output logic              tx_soc,
  output logic              tx_prty,
  output logic              tx_clav,
  output logic              tx_clav_oe
);
  localparam int unsigned WORDS = utx_pkg::cell_words(DATA_W);
  localparam int unsigned IDX_W = $clog2(WORDS);

  logic              addr_hit;
  logic              cell_full;
  logic              release_w;
  logic              busy_w;
  logic [IDX_W-1:0]  rd_idx_w;
  logic [DATA_W-1:0] rd_word_w;

  assign addr_hit = (tx_addr == cfg_phy_id);

  utx_cell_buffer #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_idx     (rd_idx_w),
    .release_i  (release_w),
    .rd_word    (rd_word_w),
    .full_o     (cell_full),
    .wr_ready_o (wr_ready)
  );

  utx_launch #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_launch (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_enb     (tx_enb),
    .addr_hit   (addr_hit),
    .cell_full  (cell_full),
    .rd_word    (rd_word_w),
    .rd_idx     (rd_idx_w),
    .release_o  (release_w),
    .busy_o     (busy_w),
    .tx_data    (tx_data),
    .tx_data_oe (tx_data_oe),
    .tx_soc     (tx_soc),
    .tx_prty    (tx_prty)
  );

  utx_clav u_clav (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_hit   (addr_hit),
    .cell_full  (cell_full),
    .busy       (busy_w),
    .tx_clav    (tx_clav),
    .tx_clav_oe (tx_clav_oe)
  );

  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |=> wr_ready && !cell_full); // R9
  AST_READY_MATCHES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready == !cell_full); // R2

endmodule

// File: tb/utopia_tx_slave_test.sv
module utopia_tx_slave_test;
  localparam int DW = 8;
  localparam int W  = (DW == 16) ? 27 : 53;
  localparam logic [4:0] MY_ID = 5'd9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    cfg_phy_id = MY_ID;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready;
  logic [4:0]    tx_addr = 5'd0;
  logic          tx_enb = 1'b0;
  logic [DW-1:0] tx_data;
  logic          tx_data_oe, tx_soc, tx_prty, tx_clav, tx_clav_oe;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [DW-1:0] m_cell [W];
  int  m_widx = 0;
  int  m_ridx = 0;
  bit  m_full = 0;
  bit  m_send = 0;
  int  words_since_soc = -1;

  always #4 clk = ~clk;

  utopia_tx_slave #(.DATA_W(DW), .ADDR_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_phy_id(cfg_phy_id),
    .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
    .tx_addr(tx_addr), .tx_enb(tx_enb), .tx_data(tx_data),
    .tx_data_oe(tx_data_oe), .tx_soc(tx_soc), .tx_prty(tx_prty),
    .tx_clav(tx_clav), .tx_clav_oe(tx_clav_oe)
  );

  function automatic logic par_odd(input logic [DW-1:0] w);
    int ones = 0;
    for (int i = 0; i < DW; i++) ones += w[i];
    return (ones % 2 == 0);
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit enb, input logic [4:0] addr, input bit wen, input logic [DW-1:0] wd);
    bit hit, launch, e_clav;
    logic [DW-1:0] e_data;
    bit e_soc;
    @(negedge clk);
    tx_enb = enb; tx_addr = addr; wr_en = wen; wr_data = wd;
    hit    = (addr == MY_ID);
    launch = enb && (m_send || (hit && m_full));
    e_data = launch ? m_cell[m_ridx] : '0;
    e_soc  = launch && (m_ridx == 0);
    e_clav = hit && m_full && !(m_send || launch);
    // model update for this edge
    if (wen && !m_full) begin
      m_cell[m_widx] = wd;
      m_widx++;
      if (m_widx == W) begin m_full = 1; m_widx = 0; end
    end
    if (launch) begin
      if (m_ridx == W - 1) begin m_ridx = 0; m_send = 0; m_full = 0; end
      else begin m_ridx++; m_send = 1; end
    end
    @(posedge clk); #1;
    check("R5", "tx_data_oe", tx_data_oe, launch);
    check("R5", "tx_data", tx_data, e_data);
    check("R6", "tx_soc", tx_soc, e_soc);
    check("R7", "tx_prty", tx_prty, launch ? par_odd(e_data) : 1'b0);
    check("R3", "tx_clav_oe", tx_clav_oe, hit);
    check("R4", "tx_clav", tx_clav, e_clav);
    check("R2", "wr_ready", wr_ready, !m_full);
    // R1: count words between start-of-cell markers
    if (tx_data_oe) begin
      if (tx_soc) begin
        if (words_since_soc >= 0) check("R1", "words per cell", words_since_soc, W);
        words_since_soc = 1;
      end else if (words_since_soc >= 0) words_since_soc++;
    end
  endtask

  task automatic fill_cell(input bit poll_last);
    for (int i = 0; i < W; i++)
      step(1'b0, (poll_last && i == W - 1) ? MY_ID : 5'd3, 1'b1, DW'($urandom));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    #20;
    check("R5", "reset tx_data_oe", tx_data_oe, 0);
    check("R3", "reset tx_clav_oe", tx_clav_oe, 0);
    check("R2", "reset wr_ready", wr_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // poll own address while buffer only partly filled: no clav (R4)
    for (int i = 0; i < 10; i++) step(1'b0, MY_ID, 1'b1, DW'($urandom));
    // R10: enable with foreign address while partly filled
    step(1'b1, 5'd4, 1'b0, '0);
    // finish the cell; poll at the edge that stores the last word (R4)
    for (int i = 10; i < W - 1; i++) step(1'b0, 5'd1, 1'b1, DW'($urandom));
    step(1'b0, MY_ID, 1'b1, DW'($urandom));
    step(1'b0, MY_ID, 1'b0, '0);
    // R2: writes while full are ignored (seen later in sent words)
    for (int i = 0; i < 5; i++) step(1'b0, 5'd2, 1'b1, DW'($urandom));
    // R10: enable with foreign address, cell held but not selected
    step(1'b1, 5'd2, 1'b0, '0);
    // start cell, then gaps with foreign addresses mid-cell (R8)
    step(1'b1, MY_ID, 1'b0, '0);
    for (int i = 0; i < 4; i++) step(1'b1, 5'd7, 1'b0, '0);
    for (int i = 0; i < 3; i++) step(1'b0, MY_ID, 1'b1, DW'($urandom));
    while (m_ridx != W - 1) step(1'b1, 5'd30, 1'b0, '0);
    // R9: last launch together with a poll and a write attempt
    step(1'b1, MY_ID, 1'b1, DW'($urandom));
    step(1'b0, MY_ID, 1'b0, '0);

    // second cell filled with poll at the final write, sent back to back
    fill_cell(1'b1);
    step(1'b1, MY_ID, 1'b0, '0);
    while (m_send) step(1'b1, 5'd0, 1'b0, '0);

    // constrained random phase
    for (int i = 0; i < 6000; i++) begin
      logic [4:0] a;
      a = ($urandom % 2) ? MY_ID : 5'($urandom);
      step(($urandom % 3) != 0, a, ($urandom % 4) == 0, DW'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule